// File: doc/BRIEF.md
# Byte-Lane SEC-DED Codec

This block is the error-correction datapath that sits between a 16-bit word port and the storage array of a word memory. Each byte of a word is guarded by its own short code, so a lane can be written alone without first reading the other lane. On the write side, every byte is expanded into a 13-bit codeword: the 8 data bits unchanged, followed by a 5-bit check field. A two-lane word is therefore stored as 26 bits.

On the read side, each 13-bit lane is checked and repaired on its own. Any single flipped bit in a lane is repaired. An error of two bits is reported and is not repaired. The lane verdicts are then combined into a two-flag status. A read strobe captures the repaired word and the status. Both then hold until the next strobe, in the way that read data holds. A `flag_valid` output marks the cycle in which the status belongs to a read that has just completed.

Top module: `bytelane_ecc_codec`

## Requirements
- R1: Lane L of `wr_code` occupies bits [13L+12:13L]. Its bits [7:0] carry the data byte unchanged. Data bit i takes Hamming position 3, 5, 6, 7, 9, 10, 11, 12 for i = 0 to 7. Check bit k (k = 0 to 3, at codeword bit 8+k) is the XOR of the data bits whose position has bit k set. Bit 12 makes the XOR of all 13 bits zero.
- R2: A read of a codeword with no error returns the original word, with `flag_corr` = 0 and `flag_uncorr` = 0.
- R3: A single flipped bit anywhere in a lane is repaired. This covers data, check and parity bits. The other lane's byte is unaffected. If no lane has a double error, the status is `flag_corr` = 1 and `flag_uncorr` = 0.
- R4: Two flipped bits within one lane set `flag_uncorr`. That lane's byte is then returned exactly as stored, flips included. If the other lane is clean, the status is `flag_corr` = 0, `flag_uncorr` = 1.
- R5: The status merges the lanes as follows. It is 10 when both lanes are single errors. It is 11 when one lane is single and the other double. It is 01 when both lanes are double.
- R6: Data and status are captured at the clock edge where `rd_en` is high. `flag_valid` is high for exactly the following cycle and low otherwise.
- R7: While `rd_en` is low, `rd_data`, `flag_corr` and `flag_uncorr` keep their last values whatever `rd_code` carries.
- R8: During and right after reset, `rd_data`, both flags and `flag_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 16 | Word to be stored |
| wr_code | output | 26 | Encoded word, combinational from `wr_data` |
| rd_en | input | 1 | Read strobe with outputs enabled |
| rd_code | input | 26 | Codeword read back from storage |
| rd_data | output | 16 | Repaired read word |
| flag_corr | output | 1 | A single-bit error was repaired in some lane |
| flag_uncorr | output | 1 | Some lane holds an unrepairable error |
| flag_valid | output | 1 | Status belongs to the read just completed |

## Verification
The two lane decoders can disagree in the same read: one repairs a bit while the other declares its byte lost. That case must produce the 11 status and still return the repaired byte in its own lane. It is provoked by crossing every per-lane pattern with every other: no error, each of the 13 single flips, and each of the 78 double flips. The expected word and flags are computed from this arithmetic alone. Each read is followed by an idle cycle carrying a corrupted codeword, which judges that the held result does not move and that `flag_valid` drops.

// File: rtl/lane_ecc_pkg.sv
package lane_ecc_pkg;
    localparam int unsigned LANE_DW = 8;
    localparam int unsigned LANE_HW = 4;
    localparam int unsigned LANE_CW = LANE_DW + LANE_HW + 1;

    // Hamming position of data bit idx: the idx-th position that is not a power of two
    function automatic logic [LANE_HW-1:0] hpos(input int unsigned idx);
        int unsigned n;
        logic [LANE_HW-1:0] r;
        n = 0;
        r = '0;
        for (int unsigned p = 1; p < (1 << LANE_HW); p++) begin
            if ((p & (p - 1)) != 0) begin
                if (n == idx) r = LANE_HW'(p);
                n++;
            end
        end
        return r;
    endfunction

    // Data bits covered by check bit k
    function automatic logic [LANE_DW-1:0] cover_mask(input int unsigned k);
        logic [LANE_DW-1:0] m;
        logic [LANE_HW-1:0] p;
        for (int unsigned i = 0; i < LANE_DW; i++) begin
            p = hpos(i);
            m[i] = p[k];
        end
        return m;
    endfunction

    localparam logic [LANE_HW-1:0] LANE_TOP_POS = hpos(LANE_DW - 1);
endpackage

// File: rtl/lane_ecc_enc.sv
module lane_ecc_enc
    import lane_ecc_pkg::*;
(
    input  logic [LANE_DW-1:0] data_i,
    output logic [LANE_CW-1:0] code_o
);
    logic [LANE_HW-1:0] chk;

    always_comb begin
        for (int unsigned k = 0; k < LANE_HW; k++) begin
            chk[k] = ^(data_i & cover_mask(k));
        end
        code_o = {^{chk, data_i}, chk, data_i};
    end
endmodule

// File: rtl/lane_ecc_dec.sv
module lane_ecc_dec
    import lane_ecc_pkg::*;
(
    input  logic [LANE_CW-1:0] code_i,
    output logic [LANE_DW-1:0] data_o,
    output logic               corr_o,
    output logic               unc_o
);
    logic [LANE_HW-1:0] syn;
    logic               odd;

    always_comb begin
        for (int unsigned k = 0; k < LANE_HW; k++) begin
            syn[k] = code_i[LANE_DW + k] ^ (^(code_i[LANE_DW-1:0] & cover_mask(k)));
        end
        odd    = ^code_i;
        data_o = code_i[LANE_DW-1:0];
        corr_o = 1'b0;
        unc_o  = 1'b0;
        if (odd) begin
            // odd weight: one flip, unless the syndrome points past the last position
            if (syn > LANE_TOP_POS) begin
                unc_o = 1'b1;
            end else begin
                corr_o = 1'b1;
                for (int unsigned i = 0; i < LANE_DW; i++) begin
                    if (syn == hpos(i)) data_o[i] = ~code_i[i];
                end
            end
        end else if (syn != '0) begin
            unc_o = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_flag_merge.sv
module ecc_flag_merge #(
    parameter int unsigned LANES = 2
) (
    input  logic [LANES-1:0] corr_i,
    input  logic [LANES-1:0] unc_i,
    output logic             corr_o,
    output logic             unc_o
);
    always_comb begin
        corr_o = |corr_i;
        unc_o  = |unc_i;
    end
endmodule

// File: rtl/bytelane_ecc_codec.sv
module bytelane_ecc_codec
    import lane_ecc_pkg::*;
#(
    parameter int unsigned LANES   = 2,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES*LANE_DW-1:0]   wr_data,
    output logic [LANES*LANE_CW-1:0]   wr_code,
    input  logic                       rd_en,
    input  logic [LANES*LANE_CW-1:0]   rd_code,
    output logic [LANES*LANE_DW-1:0]   rd_data,
    output logic                       flag_corr,
    output logic                       flag_uncorr,
    output logic                       flag_valid
);
    localparam int unsigned WORD_W = LANES * LANE_DW;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              corr;
        logic              unc;
        logic              vld;
    } hold_t;

    hold_t             hold_d, hold_q;
    logic [WORD_W-1:0] dec_data;
    logic [LANES-1:0]  lane_corr, lane_unc;
    logic              any_corr, any_unc;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ecc_enc u_enc (
            .data_i (wr_data[g*LANE_DW +: LANE_DW]),
            .code_o (wr_code[g*LANE_CW +: LANE_CW])
        );
        lane_ecc_dec u_dec (
            .code_i (rd_code[g*LANE_CW +: LANE_CW]),
            .data_o (dec_data[g*LANE_DW +: LANE_DW]),
            .corr_o (lane_corr[g]),
            .unc_o  (lane_unc[g])
        );
    end

    ecc_flag_merge #(.LANES(LANES)) u_merge (
        .corr_i (lane_corr),
        .unc_i  (lane_unc),
        .corr_o (any_corr),
        .unc_o  (any_unc)
    );

    always_comb begin
        hold_d     = hold_q;
        hold_d.vld = rd_en;
        if (rd_en) begin
            hold_d.data = dec_data;
            hold_d.corr = any_corr;
            hold_d.unc  = any_unc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    if (OUT_REG) begin : g_reg_out
        assign rd_data     = hold_q.data;
        assign flag_corr   = hold_q.corr;
        assign flag_uncorr = hold_q.unc;
        assign flag_valid  = hold_q.vld;

        AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> flag_valid);  // R6
        AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> !flag_valid);  // R6
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> ($stable(rd_data) && $stable(flag_corr) && $stable(flag_uncorr)));  // R7
        AST_CLEAN_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_code == wr_code) |=>
                (!flag_corr && !flag_uncorr && rd_data == $past(wr_data)));  // R2
        AST_SINGLE_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && $countones(rd_code ^ wr_code) == 1) |=>
                (flag_corr && !flag_uncorr && rd_data == $past(wr_data)));  // R3
    end else begin : g_comb_out
        assign rd_data     = rd_en ? dec_data : hold_q.data;
        assign flag_corr   = rd_en ? any_corr : hold_q.corr;
        assign flag_uncorr = rd_en ? any_unc  : hold_q.unc;
        assign flag_valid  = rd_en;
    end
endmodule

// File: tb/bytelane_ecc_codec_test.sv
`timescale 1ns/1ps
module bytelane_ecc_codec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic [25:0] wr_code;
    logic        rd_en = 1'b0;
    logic [25:0] rd_code = '0;
    logic [15:0] rd_data;
    logic        flag_corr, flag_uncorr, flag_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bytelane_ecc_codec uut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
        .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_data),
        .flag_corr(flag_corr), .flag_uncorr(flag_uncorr), .flag_valid(flag_valid)
    );

    function automatic logic [12:0] model_enc(input logic [7:0] d);
        int pos [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [3:0] c = '0;
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 8; i++)
                if (((pos[i] >> k) & 1) == 1) c[k] = c[k] ^ d[i];
        return {^{c, d}, c, d};
    endfunction

    function automatic logic [25:0] model_word(input logic [15:0] w);
        return {model_enc(w[15:8]), model_enc(w[7:0])};
    endfunction

    // 0: none, 1..13: single flips, 14..91: double flips
    function automatic logic [12:0] pat(input int n);
        int c = 1;
        if (n == 0) return '0;
        for (int a = 0; a < 13; a++) begin
            if (c == n) return 13'd1 << a;
            c++;
        end
        for (int a = 0; a < 13; a++)
            for (int b = a + 1; b < 13; b++) begin
                if (c == n) return (13'd1 << a) | (13'd1 << b);
                c++;
            end
        return '0;
    endfunction

    task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] w, input int n0, input int n1);
        logic [12:0] p0, p1;
        logic [7:0]  b0, b1;
        logic        ec, eu;
        string       req;
        logic [18:0] got;
        p0 = pat(n0);
        p1 = pat(n1);
        b0 = (n0 > 13) ? (w[7:0]  ^ p0[7:0]) : w[7:0];
        b1 = (n1 > 13) ? (w[15:8] ^ p1[7:0]) : w[15:8];
        ec = (n0 >= 1 && n0 <= 13) || (n1 >= 1 && n1 <= 13);
        eu = (n0 > 13) || (n1 > 13);
        if (n0 != 0 && n1 != 0) req = "R5";
        else if (eu)            req = "R4";
        else if (ec)            req = "R3";
        else                    req = "R2";
        @(negedge clk);
        wr_data = w;
        rd_code = model_word(w) ^ {p1, p0};
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        got = {rd_data, flag_corr, flag_uncorr, flag_valid};
        compare(req, 32'(got), 32'({b1, b0, ec, eu, 1'b1}));
        rd_code = ~rd_code;
        @(negedge clk);
        // R6 and R7: idle cycle with garbage code, result held, valid dropped
        compare("R7/R6 hold", 32'({rd_data, flag_corr, flag_uncorr, flag_valid}),
                32'({got[18:1], 1'b0}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R8 in reset", 32'({rd_data, flag_corr, flag_uncorr, flag_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R8 after reset", 32'({rd_data, flag_corr, flag_uncorr, flag_valid}), 32'd0);

        // R1: encoder over every byte value in both lanes
        for (int b = 0; b < 256; b++) begin
            wr_data = {~8'(b), 8'(b)};
            #1;
            compare("R1 encode", 32'(wr_code), 32'(model_word(wr_data)));
        end

        // R2..R5: cross product of per-lane patterns
        for (int n0 = 0; n0 < 92; n0++)
            for (int n1 = 0; n1 < 92; n1++)
                do_read({8'(n1 * 29 + 7), 8'(n0 * 53 + 1)}, n0, n1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule